// File: doc/BRIEF.md
# Mesh XY Router Tile

This block is one router tile of a two-dimensional mesh on-chip network. Five ports carry flits with valid/ready handshaking: four link ports to the neighbouring tiles and one Local port to the core of the tile. A header flit holds a 64-bit destination address. The router reads the Y and X tile coordinates from the upper half of that address and steers the packet by dimension-ordered routing. The packet first travels along X until the column matches. Only then does it travel along Y. The tile's own coordinates arrive on static input ports.

A packet is one header flit followed by any number of body flits, and the final flit is flagged. When a header wins an output, that output stays bound to the same input until the flagged flit has passed. Each output runs its own round-robin arbiter, and each input has a small FIFO that applies backpressure, so no flit is ever lost.

A header can also carry a multicast flag and a second corner. The packet is then copied to every tile in the inclusive rectangle that runs from the address corner to the far corner. It fans out along X across the columns of the rectangle and forks into Y wherever its column lies inside the rectangle. An input retires a multicast flit only after every output it forks to has taken that flit.

Top module: `mesh_xy_router`

## Requirements
- R1: Port indices are fixed: 0 Local, 1 North, 2 South, 3 East, 4 West. Each flit has the fields last (top bit), mcast, far (32 bits, far Y in [31:16] and far X in [15:0]) and data (64 bits).
- R2: A unicast header goes East when the destination X is larger than own X, and West when it is smaller. When X is equal it goes North for a larger Y and South for a smaller Y. When both are equal it goes Local. X is always resolved before Y.
- R3: The destination Y occupies data[63:48] and the destination X occupies data[47:32]. The bits data[31:0] never affect routing and are forwarded unchanged.
- R4: A flit accepted on an input at a clock edge is presented on its free output right after that edge, which is one cycle per hop.
- R5: Once a header is granted an output, only flits of that packet appear on that output until its last flit has transferred.
- R6: Each output grants competing headers in round-robin order over the port indices, starting after the last winner.
- R7: Flits are never dropped or reordered within an input. An output whose valid is high and whose ready is low keeps valid and the flit stable. An input's ready is low while its FIFO holds FIFO_DEPTH flits (default 2).
- R8: A multicast header names an inclusive rectangle with lower corner (address X, Y) and upper corner (far X, Y), where lower is not above upper. When the flit arrives travelling in X (from Local, East or West) and own X is outside the range, it moves toward the range. When own X is inside the range, it continues along X away from its arrival side while the range extends that way, goes Local if own Y is inside the range, goes North if own Y is below the upper Y, and goes South if own Y is above the lower Y. When it arrives travelling in Y (from North or South), it goes Local if own Y is inside the range and keeps its direction while own Y has not reached the range edge it is heading for.
- R9: A forked flit leaves its input FIFO only when every output it forks to has accepted it. Each output may accept it in a different cycle, and the flit is sent to each output exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_x | input | 16 | X coordinate of this tile |
| my_y | input | 16 | Y coordinate of this tile |
| in_valid | input | 5 | Per-input flit valid |
| in_ready | output | 5 | Per-input ready (FIFO not full) |
| in_flit | input | 5*FLIT_W | Input flits, port p at bits [p*FLIT_W +: FLIT_W] |
| out_valid | output | 5 | Per-output flit valid |
| out_ready | input | 5 | Per-output ready from the downstream side |
| out_flit | output | 5*FLIT_W | Output flits, same packing as in_flit |

## Verification
The bench aims unicast headers at each direction from a tile at (2,2). It includes a destination that differs in both X and Y, so a router that resolved Y first would turn North instead of West. It also sets the low 32 address bits to all ones, which would misroute a design that decoded the wrong field. Five multicast rectangles are seen from different arrival sides, and each has an exact fork mask; a wrong boundary comparison or a reflection toward the arrival side would show up as an extra or missing output bit. Other scenarios hold back one forked output, make two multi-flit packets race for East, send three sustained streams into East, and stall East under a filling FIFO. These expose, in turn, a duplicated or early-retired fork, interleaved wormhole packets, a starving arbiter, and a lost or overwritten flit.

// File: rtl/noc_pkg.sv
package noc_pkg;
  localparam int NPORT   = 5;
  localparam int COORD_W = 16;
  localparam int ADDR_W  = 64;
  localparam int Y_LSB   = 48;
  localparam int X_LSB   = 32;

  typedef enum logic [2:0] {
    P_LOCAL = 3'd0,
    P_NORTH = 3'd1,
    P_SOUTH = 3'd2,
    P_EAST  = 3'd3,
    P_WEST  = 3'd4
  } port_e;

  typedef struct packed {
    logic              last;
    logic              mcast;
    logic [31:0]       far;
    logic [ADDR_W-1:0] data;
  } flit_t;

  localparam int FLIT_W = $bits(flit_t);
endpackage

// File: rtl/noc_in_fifo.sv
module noc_in_fifo
  import noc_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  flit_t din,
  input  logic  pop,
  output logic  full,
  output logic  nonempty,
  output flit_t dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  flit_t          mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;

  assign full     = (cnt == CW'(DEPTH));
  assign nonempty = (cnt != '0);
  assign dout     = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7: occupancy never exceeds the storage
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/noc_route.sv
module noc_route
  import noc_pkg::*;
#(
  parameter int IN_DIR = 0
) (
  input  logic               mc,
  input  logic [COORD_W-1:0] xa,
  input  logic [COORD_W-1:0] ya,
  input  logic [COORD_W-1:0] xb,
  input  logic [COORD_W-1:0] yb,
  input  logic [COORD_W-1:0] my_x,
  input  logic [COORD_W-1:0] my_y,
  output logic [NPORT-1:0]   dmask
);
  localparam bit FROM_Y = (IN_DIR == int'(P_NORTH)) || (IN_DIR == int'(P_SOUTH));

  logic yin;
  assign yin = (my_y >= ya) && (my_y <= yb);

  always_comb begin
    dmask = '0;
    if (!mc) begin
      if      (xa > my_x) dmask[P_EAST]  = 1'b1;
      else if (xa < my_x) dmask[P_WEST]  = 1'b1;
      else if (ya > my_y) dmask[P_NORTH] = 1'b1;
      else if (ya < my_y) dmask[P_SOUTH] = 1'b1;
      else                dmask[P_LOCAL] = 1'b1;
    end else if (FROM_Y) begin
      dmask[P_LOCAL] = yin;
      if (IN_DIR == int'(P_SOUTH)) dmask[P_NORTH] = (my_y < yb);
      else                         dmask[P_SOUTH] = (my_y > ya);
    end else if (my_x < xa) begin
      dmask[P_EAST] = 1'b1;
    end else if (my_x > xb) begin
      dmask[P_WEST] = 1'b1;
    end else begin
      dmask[P_EAST]  = (my_x < xb) && (IN_DIR != int'(P_EAST));
      dmask[P_WEST]  = (my_x > xa) && (IN_DIR != int'(P_WEST));
      dmask[P_LOCAL] = yin;
      dmask[P_NORTH] = (my_y < yb);
      dmask[P_SOUTH] = (my_y > ya);
    end
  end
endmodule

// File: rtl/noc_rr_arb.sv
module noc_rr_arb #(
  parameter int N = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 adv,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (!any && req[(int'(ptr) + k) % N]) begin
        any = 1'b1;
        idx = IW'((int'(ptr) + k) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/mesh_xy_router.sv
module mesh_xy_router
  import noc_pkg::*;
#(
  parameter int FIFO_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [COORD_W-1:0]      my_x,
  input  logic [COORD_W-1:0]      my_y,
  input  logic [NPORT-1:0]        in_valid,
  output logic [NPORT-1:0]        in_ready,
  input  logic [NPORT*FLIT_W-1:0] in_flit,
  output logic [NPORT-1:0]        out_valid,
  input  logic [NPORT-1:0]        out_ready,
  output logic [NPORT*FLIT_W-1:0] out_flit
);
  localparam int IW = $clog2(NPORT);

  flit_t            in_f [NPORT];
  flit_t            head [NPORT];
  logic [NPORT-1:0] hvalid, full, pop, in_pkt;
  logic [NPORT-1:0] rmask [NPORT];
  logic [NPORT-1:0] pmask [NPORT];
  logic [NPORT-1:0] mask  [NPORT];
  logic [NPORT-1:0] sent  [NPORT];
  logic [NPORT-1:0] acc   [NPORT];
  logic [NPORT-1:0] reqv  [NPORT];
  logic [NPORT-1:0] lock_v, gnt_v, arb_any;
  logic [IW-1:0]    lock_src [NPORT];
  logic [IW-1:0]    arb_idx  [NPORT];
  logic [IW-1:0]    gnt_src  [NPORT];

  // per-output requests from inputs whose current flit still owes this output
  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        reqv[o][i] = hvalid[i] && mask[i][o] && !sent[i][o];
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        acc[i][o] = gnt_v[o] && (gnt_src[o] == IW'(i)) && out_ready[o];
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    assign in_f[i]     = flit_t'(in_flit[i*FLIT_W +: FLIT_W]);
    assign in_ready[i] = !full[i];

    noc_in_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .push     (in_valid[i] && !full[i]),
      .din      (in_f[i]),
      .pop      (pop[i]),
      .full     (full[i]),
      .nonempty (hvalid[i]),
      .dout     (head[i])
    );

    noc_route #(.IN_DIR(i)) u_route (
      .mc    (head[i].mcast),
      .xa    (head[i].data[X_LSB +: COORD_W]),
      .ya    (head[i].data[Y_LSB +: COORD_W]),
      .xb    (head[i].far[15:0]),
      .yb    (head[i].far[31:16]),
      .my_x  (my_x),
      .my_y  (my_y),
      .dmask (rmask[i])
    );

    assign mask[i] = in_pkt[i] ? pmask[i] : rmask[i];
    assign pop[i]  = hvalid[i] && (((sent[i] | acc[i]) & mask[i]) == mask[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        in_pkt[i] <= 1'b0;
        pmask[i]  <= '0;
        sent[i]   <= '0;
      end else if (pop[i]) begin
        in_pkt[i] <= !head[i].last;
        pmask[i]  <= mask[i];
        sent[i]   <= '0;
      end else begin
        sent[i]   <= sent[i] | acc[i];
      end
    end

    // R2: a unicast header selects exactly one output
    p_unicast_onehot_r2: assert property (@(posedge clk) disable iff (rst)
      hvalid[i] && !in_pkt[i] && !head[i].mcast |-> $onehot(rmask[i]));
    // R8: an ordered multicast rectangle always forks somewhere
    p_mc_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
      hvalid[i] && !in_pkt[i] && head[i].mcast
      && head[i].data[X_LSB +: COORD_W] <= head[i].far[15:0]
      && head[i].data[Y_LSB +: COORD_W] <= head[i].far[31:16]
      |-> rmask[i] != '0);
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic last_tx;

    noc_rr_arb #(.N(NPORT)) u_arb (
      .clk (clk),
      .rst (rst),
      .req (reqv[o]),
      .adv (arb_any[o] && !lock_v[o]),
      .any (arb_any[o]),
      .idx (arb_idx[o])
    );

    assign gnt_v[o]   = lock_v[o] ? reqv[o][lock_src[o]] : arb_any[o];
    assign gnt_src[o] = lock_v[o] ? lock_src[o] : arb_idx[o];
    assign last_tx    = gnt_v[o] && out_ready[o] && head[gnt_src[o]].last;

    always_ff @(posedge clk) begin
      if (rst) begin
        lock_v[o]   <= 1'b0;
        lock_src[o] <= '0;
      end else if (last_tx) begin
        lock_v[o]   <= 1'b0;
      end else if (gnt_v[o] && !lock_v[o]) begin
        lock_v[o]   <= 1'b1;
        lock_src[o] <= arb_idx[o];
      end
    end

    assign out_valid[o]                  = gnt_v[o];
    assign out_flit[o*FLIT_W +: FLIT_W]  = head[gnt_src[o]];

    // R7: a stalled output holds its flit
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_flit[o*FLIT_W +: FLIT_W]));
    // R5: the binding survives until the last flit leaves
    p_lock_keep_r5: assert property (@(posedge clk) disable iff (rst)
      lock_v[o] && !last_tx |=> lock_v[o] && $stable(lock_src[o]));
  end
endmodule

// File: tb/mesh_xy_router_bench.sv
module mesh_xy_router_bench;
  import noc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MYX = 2;
  localparam int MYY = 2;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [NPORT-1:0]        in_valid = '0;
  logic [NPORT-1:0]        in_ready;
  logic [NPORT*FLIT_W-1:0] in_flit = '0;
  logic [NPORT-1:0]        out_valid;
  logic [NPORT-1:0]        out_ready = '1;
  logic [NPORT*FLIT_W-1:0] out_flit;

  int checks = 0;
  int errors = 0;
  logic [31:0] elog [64];
  int en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesh_xy_router u_mesh_xy_router (
    .clk(clk), .rst(rst), .my_x(16'(MYX)), .my_y(16'(MYY)),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
  );

  function automatic flit_t mk(int dx, int dy, logic [31:0] off, bit last,
                               bit mc, int fx, int fy);
    flit_t f;
    f.last  = last;
    f.mcast = mc;
    f.far   = {16'(fy), 16'(fx)};
    f.data  = {16'(dy), 16'(dx), off};
    return f;
  endfunction

  function automatic flit_t outf(int p);
    return flit_t'(out_flit[p*FLIT_W +: FLIT_W]);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_in(int p, flit_t f, bit v);
    in_flit[p*FLIT_W +: FLIT_W] = f;
    in_valid[p] = v;
  endtask

  // east-port monitor, sampled after the bench's negedge updates
  always begin
    @(negedge clk);
    #1;
    if (!rst && out_valid[P_EAST] && out_ready[P_EAST] && en < 64) begin
      elog[en] = outf(P_EAST).data[31:0];
      en++;
    end
  end

  task automatic drive_pkt(int p, int dx, int dy, logic [3:0] tag, int n, bit each_last);
    for (int k = 0; k < n; k++) begin
      bit r;
      set_in(p, mk(dx, dy, {tag, 24'h0, 4'(k)}, each_last || (k == n-1), 1'b0, 0, 0), 1'b1);
      do begin
        r = in_ready[p];
        @(negedge clk);
      end while (!r);
    end
    in_valid[p] = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == '0, "R7", "reset out_valid", 64'(out_valid), 64'h0);
    chk(in_ready == '1, "R7", "reset in_ready", 64'(in_ready), 64'h1f);
  endtask

  // R1 R2 R3 R4: single-flit unicast, one-cycle hop, then idle
  task automatic t_uni(int p, int dx, int dy, logic [31:0] off, int ep, string req);
    flit_t f;
    f = mk(dx, dy, off, 1'b1, 1'b0, 0, 0);
    @(negedge clk);
    set_in(p, f, 1'b1);
    @(negedge clk);
    in_valid[p] = 1'b0;
    chk(out_valid == 5'(1 << ep), req, "unicast port (R4 one cycle)", 64'(out_valid), 64'(1 << ep));
    chk(outf(ep).data == f.data, "R3", "unicast data", outf(ep).data, f.data);
    @(negedge clk);
    chk(out_valid == '0, req, "unicast drained", 64'(out_valid), 64'h0);
  endtask

  task automatic t_mc(int p, int xa, int ya, int xb, int yb, logic [4:0] exp);
    flit_t f;
    f = mk(xa, ya, 32'hC0DE_0000 + 32'(p), 1'b1, 1'b1, xb, yb);
    @(negedge clk);
    set_in(p, f, 1'b1);
    @(negedge clk);
    in_valid[p] = 1'b0;
    chk(out_valid == exp, "R8", "multicast fork mask", 64'(out_valid), 64'(exp));
    for (int o = 0; o < NPORT; o++)
      if (exp[o]) chk(outf(o).data == f.data, "R8", "multicast copy", outf(o).data, f.data);
    @(negedge clk);
    chk(out_valid == '0, "R9", "multicast retired", 64'(out_valid), 64'h0);
  endtask

  task automatic t_partial();
    flit_t f;
    f = mk(1, 1, 32'h5151_0001, 1'b1, 1'b1, 3, 3);
    @(negedge clk);
    out_ready = 5'b11101;
    set_in(P_LOCAL, f, 1'b1);
    @(negedge clk);
    in_valid[P_LOCAL] = 1'b0;
    chk(out_valid == 5'h1f, "R9", "fork all", 64'(out_valid), 64'h1f);
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 5'b00010, "R9", "only stalled branch pending", 64'(out_valid), 64'h2);
      chk(outf(P_NORTH).data == f.data, "R7", "stalled copy stable", outf(P_NORTH).data, f.data);
    end
    out_ready = '1;
    @(negedge clk);
    chk(out_valid == '0, "R9", "retired after last branch", 64'(out_valid), 64'h0);
  endtask

  task automatic t_worm();
    @(negedge clk);
    en = 0;
    fork
      drive_pkt(P_WEST,  5, 2, 4'hA, 3, 1'b0);
      drive_pkt(P_LOCAL, 5, 2, 4'hB, 3, 1'b0);
    join
    repeat (6) @(negedge clk);
    chk(en == 6, "R5", "east flit count", 64'(en), 64'd6);
    for (int k = 0; k < 3; k++) begin
      chk(elog[k][31:28] == elog[0][31:28], "R5", "first packet contiguous", 64'(elog[k]), 64'(elog[0]));
      chk(elog[k+3][31:28] == elog[3][31:28], "R5", "second packet contiguous", 64'(elog[k+3]), 64'(elog[3]));
      chk(elog[k][3:0] == 4'(k), "R7", "body order", 64'(elog[k][3:0]), 64'(k));
    end
    chk(elog[0][31:28] != elog[3][31:28], "R5", "both packets seen", 64'(elog[3]), 64'(elog[0]));
  endtask

  task automatic t_rr();
    int seq [4];
    @(negedge clk);
    en = 0;
    fork
      drive_pkt(P_LOCAL, 5, 2, 4'h1, 4, 1'b1);
      drive_pkt(P_SOUTH, 5, 2, 4'h2, 4, 1'b1);
      drive_pkt(P_WEST,  5, 2, 4'h3, 4, 1'b1);
    join
    repeat (6) @(negedge clk);
    chk(en == 12, "R7", "no flit lost", 64'(en), 64'd12);
    for (int k = 0; k + 2 < 12; k++) begin
      bit distinct;
      distinct = elog[k][31:28] != elog[k+1][31:28] && elog[k][31:28] != elog[k+2][31:28]
              && elog[k+1][31:28] != elog[k+2][31:28];
      chk(distinct, "R6", "round-robin window", 64'(elog[k+1]), 64'(elog[k]));
    end
    for (int t = 0; t < 4; t++) seq[t] = 0;
    for (int k = 0; k < 12; k++) begin
      int t;
      t = int'(elog[k][31:28]);
      chk(elog[k][3:0] == 4'(seq[t]), "R7", "per-input order", 64'(elog[k][3:0]), 64'(seq[t]));
      seq[t]++;
    end
  endtask

  task automatic t_bp();
    flit_t a, b;
    a = mk(5, 2, 32'h0000_AAA0, 1'b1, 1'b0, 0, 0);
    b = mk(5, 2, 32'h0000_BBB1, 1'b1, 1'b0, 0, 0);
    @(negedge clk);
    en = 0;
    out_ready[P_EAST] = 1'b0;
    set_in(P_LOCAL, a, 1'b1);
    @(negedge clk);
    set_in(P_LOCAL, b, 1'b1);
    @(negedge clk);
    in_valid[P_LOCAL] = 1'b0;
    chk(in_ready[P_LOCAL] == 1'b0, "R7", "ready low when full", 64'(in_ready[P_LOCAL]), 64'h0);
    repeat (3) begin
      chk(out_valid[P_EAST] && outf(P_EAST).data == a.data, "R7", "stalled head held",
          outf(P_EAST).data, a.data);
      @(negedge clk);
    end
    out_ready[P_EAST] = 1'b1;
    repeat (4) @(negedge clk);
    chk(en == 2, "R7", "both delivered", 64'(en), 64'd2);
    chk(elog[0] == a.data[31:0], "R7", "first out", 64'(elog[0]), 64'(a.data[31:0]));
    chk(elog[1] == b.data[31:0], "R7", "second out", 64'(elog[1]), 64'(b.data[31:0]));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    // R1 R2: port indices, X resolved before Y
    t_uni(P_LOCAL, 5, 2, 32'h1234_0000, P_EAST,  "R2");
    t_uni(P_LOCAL, 0, 7, 32'h1234_0001, P_WEST,  "R2");
    t_uni(P_LOCAL, 2, 9, 32'h1234_0002, P_NORTH, "R1");
    t_uni(P_NORTH, 2, 0, 32'h1234_0003, P_SOUTH, "R1");
    t_uni(P_EAST,  2, 2, 32'hFFFF_FFFF, P_LOCAL, "R3");
    // R8 rectangles from several arrival sides
    t_mc(P_LOCAL, 1, 1, 3, 3, 5'b11111);
    t_mc(P_LOCAL, 4, 0, 6, 5, 5'b01000);
    t_mc(P_WEST,  0, 3, 5, 4, 5'b01010);
    t_mc(P_SOUTH, 2, 1, 2, 2, 5'b00001);
    t_mc(P_NORTH, 2, 0, 2, 5, 5'b00101);
    t_partial();
    t_worm();
    t_rr();
    t_bp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule